// File: doc/BRIEF.md
# Real-Time-Clock Interrupt Flag Controller

This block keeps the interrupt state of a real-time-clock peripheral. Three event sources feed it: a periodic tick, an alarm match and the end of a time update. Each arrives as a single-cycle pulse from logic outside the block. Each source owns a pending flag and an enable bit. A summary request flag is the OR of every pending source whose enable is set. That flag drives an active-low, open-drain interrupt line, modelled as an output enable plus a constant-zero drive value, so that an external pull-up can share the line with other devices.

Software writes a control register. It holds the three source enables, a square-wave output enable and four general bits. Software reads a status register that returns the three flags and the summary flag. The read clears the flags, which releases the interrupt line. A synchronous reset clears the enables, the square-wave enable, all flags and the summary flag. It leaves the general control bits as they were.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: A pulse on a source's event input sets that source's flag at the next clock edge, whether or not its enable is set. The flag then holds until a status read or a reset.
- R2: A status read returns, one cycle later with `status_vld` high, the state held before the read. The periodic flag is bit 0, the alarm flag bit 1, the update flag bit 2, the summary flag bit 3, and bits 7:4 read 0. The flags read 0 from the next cycle.
- R3: If an event pulse and a status read fall in the same cycle, that source's flag is set after the edge. The read data shows the flag's earlier value.
- R4: The summary flag is (periodic flag AND periodic enable) OR (alarm flag AND alarm enable) OR (update flag AND update enable). It follows the flags and enables of the same cycle.
- R5: `irq_oe` is high exactly when the summary flag is set, and `irq_drv` is always 0, so the line is low only while an enabled source is pending.
- R6: Reset clears control bits 0 (periodic enable), 1 (alarm enable), 2 (update enable) and 3 (square-wave enable). Control bits 7:4 keep their value.
- R7: Reset clears all three flags and the summary flag, and `irq_oe` goes low.
- R8: A control write stores `ctrl_wdata` at the next edge, and `ctrl_q` shows it.
- R9: Clearing an enable while its flag is pending drops `irq_oe` at the next edge and leaves the flag pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_periodic | input | 1 | Periodic event pulse |
| evt_alarm | input | 1 | Alarm event pulse |
| evt_update | input | 1 | Update-ended event pulse |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | CTRL_W | Control write data |
| ctrl_q | output | CTRL_W | Control register contents |
| status_rd | input | 1 | Status read strobe (clears flags) |
| status_q | output | STAT_W | Status read data |
| status_vld | output | 1 | Status read data valid |
| irq_oe | output | 1 | Interrupt line output enable (line pulled low) |
| irq_drv | output | 1 | Interrupt line drive value, constant 0 |

## Verification
A flag that fails to set, or fails to clear, shows on the next status read. It also shows one cycle after the faulty edge as a wrong `irq_oe` level, provided that source's enable is set. A wrong gating term shows as an `irq_oe` level that does not match the enabled pending sources, and as a wrong bit 3 in the read data. If a read beside an event loses that event, the loss shows on the read that follows. If reset clears the wrong control bits, `ctrl_q` shows it one cycle after reset.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int NSRC    = 3;
  localparam int SRC_PER = 0;
  localparam int SRC_ALM = 1;
  localparam int SRC_UPD = 2;
  localparam int CTL_SQW = 3;
  localparam int STS_SUM = 3;

  function automatic logic [7:0] rst_clear_mask();
    logic [7:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++) m[i] = 1'b1;
    m[CTL_SQW] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/rtc_irq_flag.sv
module rtc_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic clr,
  output logic flag_q,
  output logic flag_nxt
);
  // event wins over a clearing read so no event is lost
  always_comb begin
    if (rst)      flag_nxt = 1'b0;
    else if (evt) flag_nxt = 1'b1;
    else if (clr) flag_nxt = 1'b0;
    else          flag_nxt = flag_q;
  end

  always_ff @(posedge clk) flag_q <= flag_nxt;
endmodule

// File: rtl/rtc_irq_ctrl_reg.sv
module rtc_irq_ctrl_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ctrl_q,
  output logic [W-1:0] ctrl_nxt
);
  // reset clears only the masked bits; the rest keep their value
  always_comb begin
    if (rst)     ctrl_nxt = ctrl_q & ~RST_MASK;
    else if (wr) ctrl_nxt = wdata;
    else         ctrl_nxt = ctrl_q;
  end

  always_ff @(posedge clk) ctrl_q <= ctrl_nxt;
endmodule

// File: rtl/rtc_irq_summary.sv
module rtc_irq_summary #(
  parameter int NSRC   = 3,
  parameter int STAT_W = 8,
  parameter int SUM_BIT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   flag_q,
  input  logic [NSRC-1:0]   flag_nxt,
  input  logic [NSRC-1:0]   en_nxt,
  input  logic              rd,
  output logic [STAT_W-1:0] status_q,
  output logic              status_vld,
  output logic              irq_oe
);
  logic              sum_q;
  logic [STAT_W-1:0] snap;

  always_comb begin
    snap = '0;
    snap[NSRC-1:0] = flag_q;
    snap[SUM_BIT]  = sum_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q      <= 1'b0;
      status_q   <= '0;
      status_vld <= 1'b0;
    end else begin
      sum_q      <= |(flag_nxt & en_nxt);
      status_vld <= rd;
      if (rd) status_q <= snap;
    end
  end

  assign irq_oe = sum_q;
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int CTRL_W = 8,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_periodic,
  input  logic              evt_alarm,
  input  logic              evt_update,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  input  logic              status_rd,
  output logic [STAT_W-1:0] status_q,
  output logic              status_vld,
  output logic              irq_oe,
  output logic              irq_drv
);
  localparam logic [7:0] MASK8 = rst_clear_mask();
  localparam logic [CTRL_W-1:0] RST_MASK = CTRL_W'(MASK8);

  logic [NSRC-1:0]   evt_v;
  logic [NSRC-1:0]   flag_q;
  logic [NSRC-1:0]   flag_nxt;
  logic [CTRL_W-1:0] ctrl_nxt;

  always_comb begin
    evt_v          = '0;
    evt_v[SRC_PER] = evt_periodic;
    evt_v[SRC_ALM] = evt_alarm;
    evt_v[SRC_UPD] = evt_update;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    rtc_irq_flag u_flag (
      .clk      (clk),
      .rst      (rst),
      .evt      (evt_v[i]),
      .clr      (status_rd),
      .flag_q   (flag_q[i]),
      .flag_nxt (flag_nxt[i])
    );
  end

  rtc_irq_ctrl_reg #(.W(CTRL_W), .RST_MASK(RST_MASK)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr       (ctrl_wr),
    .wdata    (ctrl_wdata),
    .ctrl_q   (ctrl_q),
    .ctrl_nxt (ctrl_nxt)
  );

  rtc_irq_summary #(.NSRC(NSRC), .STAT_W(STAT_W), .SUM_BIT(STS_SUM)) u_sum (
    .clk        (clk),
    .rst        (rst),
    .flag_q     (flag_q),
    .flag_nxt   (flag_nxt),
    .en_nxt     (ctrl_nxt[NSRC-1:0]),
    .rd         (status_rd),
    .status_q   (status_q),
    .status_vld (status_vld),
    .irq_oe     (irq_oe)
  );

  assign irq_drv = 1'b0;
endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
module rtc_irq_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] evt,
  input logic       rd,
  input logic [2:0] flags,
  input logic [3:0] ctl,
  input logic       irq_oe
);
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    evt[0] |=> flags[0]); // R1
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (flags[1] && !evt[1] && !rd) |=> flags[1]); // R1
  AST_RD_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (rd && !evt[2]) |=> !flags[2]); // R2
  AST_RD_EVT_KEEP: assert property (@(posedge clk) disable iff (rst)
    (rd && evt[1]) |=> flags[1]); // R3
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq_oe == |(flags & ctl[2:0])); // R4
  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (ctl == 4'h0 && flags == 3'b000 && !irq_oe)); // R7
endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .evt    (evt_v),
  .rd     (status_rd),
  .flags  (flag_q),
  .ctl    (ctrl_q[3:0]),
  .irq_oe (irq_oe)
);

// File: tb/rtc_irq_ctrl_test.sv
module rtc_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       evt_periodic = 0, evt_alarm = 0, evt_update = 0;
  logic       ctrl_wr = 0;
  logic [7:0] ctrl_wdata = '0;
  logic [7:0] ctrl_q;
  logic       status_rd = 0;
  logic [7:0] status_q;
  logic       status_vld;
  logic       irq_oe, irq_drv;

  int n_run = 0;
  int n_fail = 0;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  rtc_irq_ctrl uut (
    .clk(clk), .rst(rst),
    .evt_periodic(evt_periodic), .evt_alarm(evt_alarm), .evt_update(evt_update),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
    .status_rd(status_rd), .status_q(status_q), .status_vld(status_vld),
    .irq_oe(irq_oe), .irq_drv(irq_drv)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_ctrl(logic [7:0] v);
    ctrl_wr = 1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_wr = 0;
  endtask

  task automatic pulse(logic p, logic a, logic u);
    evt_periodic = p; evt_alarm = a; evt_update = u;
    @(negedge clk);
    evt_periodic = 0; evt_alarm = 0; evt_update = 0;
  endtask

  task automatic rd(logic [7:0] exp, string tag, logic alarm_too = 0);
    exp_t e;
    e.val = exp; e.tag = tag;
    sb.push_back(e);
    status_rd = 1; evt_alarm = alarm_too;
    @(negedge clk);
    status_rd = 0; evt_alarm = 0;
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (!rst && status_vld) begin
      if (sb.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R2: unexpected read data %h expected none", status_q);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, status_q, e.val);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R7 reset state
    chk("R7 irq_oe after reset", {7'b0, irq_oe}, 8'h00);
    chk("R5 irq_drv", {7'b0, irq_drv}, 8'h00);
    chk("R6 ctrl low bits after reset", {4'h0, ctrl_q[3:0]}, 8'h00);
    rd(8'h00, "R7 status after reset");

    // R8 write readback, R6 upper bits kept across reset
    wr_ctrl(8'hF5);
    chk("R8 ctrl readback", ctrl_q, 8'hF5);
    rst = 1; @(negedge clk); rst = 0;
    chk("R6 reset clears bits 3:0 keeps 7:4", ctrl_q, 8'hF0);

    // R1 flag sets with enable off, R4 no request
    wr_ctrl(8'h00);
    pulse(1, 0, 0);
    chk("R4 disabled source no irq", {7'b0, irq_oe}, 8'h00);
    rd(8'h01, "R1 periodic flag with enable off");
    rd(8'h00, "R2 flags cleared by read");

    // R5 enabled periodic drives line, read releases
    wr_ctrl(8'h01);
    pulse(1, 0, 0);
    chk("R5 irq_oe on enabled pending", {7'b0, irq_oe}, 8'h01);
    rd(8'h09, "R4 summary bit with periodic");
    chk("R2 read releases irq_oe", {7'b0, irq_oe}, 8'h00);

    // R4 two sources, only update enabled
    wr_ctrl(8'h04);
    pulse(0, 1, 1);
    chk("R4 update enabled irq", {7'b0, irq_oe}, 8'h01);
    rd(8'h0E, "R4 alarm+update with summary");

    // R3 event beside read
    wr_ctrl(8'h02);
    rd(8'h00, "R3 read data before same-cycle event", 1'b1);
    chk("R3 alarm kept, irq raised", {7'b0, irq_oe}, 8'h01);
    rd(8'h0A, "R3 alarm flag survived read");

    // R9 enable cleared while pending
    wr_ctrl(8'h01);
    pulse(1, 0, 0);
    chk("R9 irq before disable", {7'b0, irq_oe}, 8'h01);
    wr_ctrl(8'h00);
    chk("R9 irq drops on disable", {7'b0, irq_oe}, 8'h00);
    rd(8'h01, "R9 flag still pending, no summary");

    // R6/R7 reset with everything pending
    wr_ctrl(8'hAF);
    pulse(1, 1, 1);
    chk("R5 all pending irq", {7'b0, irq_oe}, 8'h01);
    rst = 1; @(negedge clk); rst = 0;
    chk("R7 irq_oe cleared by reset", {7'b0, irq_oe}, 8'h00);
    chk("R6 reset clears enables and square-wave", ctrl_q, 8'hA0);
    rd(8'h00, "R7 flags cleared by reset");

    repeat (3) @(negedge clk);
    chk("R2 all reads answered", 8'(sb.size()), 8'h00);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule